// File: doc/BRIEF.md
# Dual Down-Counting Timer with Register Access

The block holds two independent 32-bit timers that count down. Software reaches them through a small register bus: an address, a write strobe with write data, and a read strobe whose data appears one cycle later. The timers share one control word and one event-status word. Each timer also has its own reload word and current-count word. A timer advances only on its own tick. That tick comes either from the fabric clock divided by a power of two, or from an external reference strobe that is used as it arrives.

When a running timer sees a tick while its count is zero, it raises a sticky event, and that event drives the timer's interrupt line as a level. In periodic mode the count is refilled from the reload word, so events arrive every reload+1 ticks. In one-shot mode the timer stops at zero and stays quiet until software writes a new count. Software clears an event by writing a zero to its status bit.

Each timer is a three-state machine:
- **TS_IDLE**: the timer is disabled.
- **TS_RUN**: the timer is counting.
- **TS_HELD**: a one-shot timer has expired.

Its transitions are:
- **enable**: TS_IDLE to TS_RUN, when the enable bit is set.
- **disable**: any state to TS_IDLE, when the enable bit is cleared.
- **expire**: TS_RUN to TS_HELD, on a tick at zero with reload off.
- **refire**: TS_RUN stays in TS_RUN, on a tick at zero with reload on.
- **rearm**: TS_HELD to TS_RUN, when software writes the count word while the timer is enabled.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register reads 0, both interrupt lines are low and both timers are in TS_IDLE.
- R2: Register offsets:
  - 0x00 is control.
  - 0x04 is status.
  - 0x10 and 0x14 are timer 0 reload and count.
  - 0x18 and 0x1C are timer 1 reload and count.

  Reload and count words read back what was written. Control reads back only its defined bits (mask 0x01F8180F). Other offsets read 0. Read data is valid in the cycle after the read strobe.
- R3: A count decrements by one only on a tick of its own selected source while its timer is enabled. With no tick, or with the timer disabled, the count does not change.
- R4: With reload on, a tick at zero sets the event and refills the count from the reload word, so events are reload+1 ticks apart. Control bit 1 turns reload on for timer 0, and bit 3 does so for timer 1. Control bit 0 enables timer 0, and bit 2 enables timer 1.
- R5: With reload off, a tick at zero sets the event once. The count then stays at 0 and sets no further event until software writes the count word.
- R6: Status bit 0 is timer 0's event and bit 8 is timer 1's event. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. Each interrupt line follows its event bit.
- R7: If an event is set in the same cycle that software writes a clear for it, the event stays set.
- R8: A fabric-sourced timer ticks once every 2^N clock cycles. N is control bits 21:19 for timer 0 and bits 24:22 for timer 1. A write to the count word restarts the timer's divider phase.
- R9: Control bit 11 (timer 0) and bit 12 (timer 1) select the reference strobe as the tick source. Each cycle with the strobe high is then one tick, with no division.
- R10: A count written while the timer runs is loaded at once. A tick in the same cycle as the write is dropped, and counting resumes from the written value on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Fixed reference tick strobe, one cycle per tick |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered one cycle after bus_rd |
| irq | output | 2 | Interrupt level per timer (bit i = timer i) |

## Verification
Most counting is driven from the reference strobe. This gives an exact tick count per pulse, so the checks can tell periodic refill from one-shot hold, and decrement from no change. Fabric-divided counting is run for a fixed window that is not a multiple of the divider, which shows whether the divide ratio and the phase restart on a count write are right. Same-cycle collisions, a tick with a status clear and a tick with a count write, show which side wins. A table of register writes and readbacks covers the address decode, the control mask and unmapped offsets.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

    localparam int NUM_TMR  = 2;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 32;
    localparam int SHIFT_W  = 3;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_BANK   = 5'h10;
    localparam int               BANK_STRIDE = 8;
    localparam int               VAL_SKEW    = 4;

    localparam int EN_BIT0    = 0;
    localparam int REF_BIT0   = 11;
    localparam int SHIFT_LO0  = 19;
    localparam int EVT_STRIDE = 8;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h01F8_180F;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_RUN  = 2'd1,
        TS_HELD = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/dt_tick_gen.sv
module dt_tick_gen #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic               use_ref,
    input  logic               ref_tick,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PH_W = 1 << SHIFT_W;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] mask;

    assign mask = (PH_W'(1) << shift) - PH_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) phase <= '0;
        else                           phase <= phase + PH_W'(1);
    end

    always_comb begin
        if (!run || restart) tick = 1'b0;
        else if (use_ref)    tick = ref_tick;
        else                 tick = ((phase & mask) == mask);
    end
endmodule

// File: rtl/dt_counter.sv
module dt_counter
    import dual_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         reload_en,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] value,
    output logic         fire,
    output tmr_state_e   state
);
    tmr_state_e   nstate;
    logic [W-1:0] nvalue;

    always_comb begin
        fire = !load && enable && (state != TS_HELD) && tick && (value == '0);
    end

    always_comb begin
        nstate = state;
        nvalue = value;
        if (load) begin
            nvalue = load_val;
            nstate = enable ? TS_RUN : TS_IDLE;
        end else if (!enable) begin
            nstate = TS_IDLE;
        end else begin
            unique case (state)
                TS_IDLE, TS_RUN: begin
                    nstate = TS_RUN;
                    if (fire) begin
                        if (reload_en) nvalue = reload_val;
                        else           nstate = TS_HELD;
                    end else if (tick) begin
                        nvalue = value - W'(1);
                    end
                end
                TS_HELD: nstate = TS_HELD;
                default: nstate = TS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_IDLE;
            value <= '0;
        end else begin
            state <= nstate;
            value <= nvalue;
        end
    end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import dual_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_TMR-1:0] irq
);
    logic [DATA_W-1:0]                ctrl;
    logic [NUM_TMR-1:0][DATA_W-1:0]   reload_q;
    logic [NUM_TMR-1:0][DATA_W-1:0]   val_w;
    logic [NUM_TMR-1:0]               evt_q;
    logic [NUM_TMR-1:0]               fire_w;
    logic [NUM_TMR-1:0]               tick_w;
    logic [NUM_TMR-1:0]               load_w;
    logic [NUM_TMR-1:0]               en_w;
    logic [NUM_TMR-1:0]               rel_w;
    logic [NUM_TMR-1:0]               held_w;
    logic [DATA_W-1:0]                rd_mux;
    logic [DATA_W-1:0]                status_w;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam logic [ADDR_W-1:0] RL_OFF  = ADDR_W'(OFF_BANK + i*BANK_STRIDE);
        localparam logic [ADDR_W-1:0] VAL_OFF = ADDR_W'(OFF_BANK + i*BANK_STRIDE + VAL_SKEW);
        tmr_state_e st;

        assign en_w[i]   = ctrl[EN_BIT0 + 2*i];
        assign rel_w[i]  = ctrl[EN_BIT0 + 2*i + 1];
        assign load_w[i] = bus_wr && (bus_addr == VAL_OFF);
        assign held_w[i] = (st == TS_HELD);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_q[i] <= '0;
                evt_q[i]    <= 1'b0;
            end else begin
                if (bus_wr && bus_addr == RL_OFF) reload_q[i] <= bus_wdata;
                if (fire_w[i])
                    evt_q[i] <= 1'b1;
                else if (bus_wr && bus_addr == OFF_STATUS && !bus_wdata[EVT_STRIDE*i])
                    evt_q[i] <= 1'b0;
            end
        end

        dt_tick_gen #(.SHIFT_W(SHIFT_W)) u_tick (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (en_w[i]),
            .restart  (load_w[i]),
            .use_ref  (ctrl[REF_BIT0 + i]),
            .ref_tick (ref_tick),
            .shift    (ctrl[SHIFT_LO0 + SHIFT_W*i +: SHIFT_W]),
            .tick     (tick_w[i])
        );

        dt_counter #(.W(DATA_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (en_w[i]),
            .reload_en  (rel_w[i]),
            .tick       (tick_w[i]),
            .load       (load_w[i]),
            .load_val   (bus_wdata),
            .reload_val (reload_q[i]),
            .value      (val_w[i]),
            .fire       (fire_w[i]),
            .state      (st)
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl <= '0;
        else if (bus_wr && bus_addr == OFF_CTRL) ctrl <= bus_wdata & CTRL_MASK;
    end

    always_comb begin
        status_w = '0;
        for (int i = 0; i < NUM_TMR; i++) status_w[EVT_STRIDE*i] = evt_q[i];
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFF_CTRL)   rd_mux = ctrl;
        if (bus_addr == OFF_STATUS) rd_mux = status_w;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(OFF_BANK + i*BANK_STRIDE))            rd_mux = reload_q[i];
            if (bus_addr == ADDR_W'(OFF_BANK + i*BANK_STRIDE + VAL_SKEW)) rd_mux = val_w[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = evt_q;
endmodule

// File: rtl/dt_checker.sv
module dt_checker
    import dual_timer_pkg::*;
(
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_TMR-1:0]              irq,
    input logic [NUM_TMR-1:0]              fire,
    input logic [NUM_TMR-1:0]              tick,
    input logic [NUM_TMR-1:0]              load,
    input logic [NUM_TMR-1:0]              en,
    input logic [NUM_TMR-1:0]              rel,
    input logic [NUM_TMR-1:0]              held,
    input logic [NUM_TMR-1:0][DATA_W-1:0]  value,
    input logic [NUM_TMR-1:0][DATA_W-1:0]  reload
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        a_r6_fire_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> irq[i]);
        a_r5_held_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
            held[i] |-> (value[i] == '0));
        a_r3_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick[i] && !load[i]) |=> $stable(value[i]));
        a_r4_refill: assert property (@(posedge clk) disable iff (!rst_n)
            (fire[i] && rel[i]) |=> (value[i] == $past(reload[i])));
        a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[i] && !load[i] && en[i] && !held[i] && value[i] != '0)
            |=> (value[i] == $past(value[i]) - 1));
    end
endmodule

bind dual_down_timer dt_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq),
    .fire   (fire_w),
    .tick   (tick_w),
    .load   (load_w),
    .en     (en_w),
    .rel    (rel_w),
    .held   (held_w),
    .value  (val_w),
    .reload (reload_q)
);

// File: tb/dual_down_timer_test.sv
module dual_down_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    dual_down_timer uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h10, 32'h1234_5678, 32'h0},
        '{1'b1, 5'h14, 32'hDEAD_BEEF, 32'h0},
        '{1'b1, 5'h18, 32'hA5A5_0F0F, 32'h0},
        '{1'b1, 5'h1C, 32'h0000_00C3, 32'h0},
        '{1'b0, 5'h10, 32'h0,         32'h1234_5678},
        '{1'b0, 5'h14, 32'h0,         32'hDEAD_BEEF},
        '{1'b0, 5'h18, 32'h0,         32'hA5A5_0F0F},
        '{1'b0, 5'h1C, 32'h0,         32'h0000_00C3},
        '{1'b1, 5'h00, 32'hFFFF_FFF0, 32'h0},
        '{1'b0, 5'h00, 32'h0,         32'h01F8_1800},
        '{1'b1, 5'h00, 32'h0,         32'h0},
        '{1'b0, 5'h08, 32'h0,         32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    task automatic pulse_wr(input logic [4:0] a, input logic [31:0] d);
        ref_tick = 1'b1; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {30'b0, irq}, 32'h0);
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), rv);
            check("R1 reset read", rv, 32'h0);
        end

        // R2 register map table
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) wr(VECS[v].addr, VECS[v].data);
            else begin
                rd(VECS[v].addr, rv);
                check("R2 map", rv, VECS[v].exp);
            end
        end

        // R9 / R3 reference tick counting on timer 0
        wr(5'h14, 32'd5);
        wr(5'h00, 32'h0000_0801);
        pulse(2);
        rd(5'h14, rv); check("R9 ref ticks", rv, 32'd3);
        repeat (10) @(negedge clk);
        rd(5'h14, rv); check("R3 no tick no change", rv, 32'd3);

        // R4 periodic
        wr(5'h10, 32'd2);
        wr(5'h14, 32'd2);
        wr(5'h00, 32'h0000_0803);
        pulse(2);
        rd(5'h04, rv); check("R4 not yet", rv, 32'h0);
        pulse(1);
        rd(5'h04, rv); check("R4 event", rv, 32'h1);
        rd(5'h14, rv); check("R4 refill", rv, 32'd2);
        check("R6 irq level", {30'b0, irq}, 32'h1);
        wr(5'h04, 32'h0000_0100);
        rd(5'h04, rv); check("R6 clear", rv, 32'h0);
        check("R6 irq low", {30'b0, irq}, 32'h0);
        pulse(3);
        rd(5'h04, rv); check("R4 period", rv, 32'h1);
        wr(5'h04, 32'h0000_0001);
        rd(5'h04, rv); check("R6 write one keeps", rv, 32'h1);
        wr(5'h04, 32'h0);

        // R7 set beats clear
        pulse(2);
        pulse_wr(5'h04, 32'h0);
        rd(5'h04, rv); check("R7 set wins", rv, 32'h1);

        // R10 write during tick
        pulse_wr(5'h14, 32'd7);
        rd(5'h14, rv); check("R10 write wins", rv, 32'd7);
        pulse(1);
        rd(5'h14, rv); check("R10 resumes", rv, 32'd6);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);

        // R5 one-shot on timer 1
        wr(5'h1C, 32'd1);
        wr(5'h00, 32'h0000_1004);
        pulse(2);
        rd(5'h04, rv); check("R5 fires", rv, 32'h100);
        check("R6 irq1", {30'b0, irq}, 32'h2);
        wr(5'h04, 32'h0);
        pulse(3);
        rd(5'h04, rv); check("R5 no refire", rv, 32'h0);
        rd(5'h1C, rv); check("R5 holds zero", rv, 32'h0);
        wr(5'h1C, 32'h0);
        pulse(1);
        rd(5'h04, rv); check("R5 rearm", rv, 32'h100);
        wr(5'h04, 32'h0);
        wr(5'h00, 32'h0);

        // R8 fabric divide by 4 over 41 cycles
        wr(5'h1C, 32'd100);
        wr(5'h00, 32'h0080_0004);
        repeat (40) @(negedge clk);
        wr(5'h00, 32'h0080_0000);
        rd(5'h1C, rv); check("R8 divide", rv, 32'd100 - 32'(41 / 4));

        // R8 phase restart on count write
        wr(5'h00, 32'h0080_0004);
        repeat (2) @(negedge clk);
        wr(5'h1C, 32'd50);
        repeat (2) @(negedge clk);
        wr(5'h00, 32'h0);
        rd(5'h1C, rv); check("R8 phase restart", rv, 32'd50);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule